// File: doc/BRIEF.md
# Configurable Multiplexed I/O Port

This block runs a bank of general-purpose pads, eight by default. Three control bytes decide what each pad does. The first is a port latch byte holding the value to drive. The second is a direction byte. The third is an ownership byte that can hand the pad to an on-chip peripheral. If the ownership bit is set, the peripheral's own data and enable reach the pad. If it is clear and the direction bit is clear, the pad is a push-pull output of the latch bit. If the direction bit is set, the latch bit decides between two behaviours. A latch bit of 1 releases the pad so that it works as an input. A latch bit of 0 makes the pad an open-drain output that pulls low.

Software programs the port through a small register interface with a two-bit address. The latch byte is at address 0, the direction byte at address 1, the ownership byte at address 2, and the read-only pin-level byte at address 3. Pad levels pass through a two-flop synchronizer. The synchronized levels are readable at address 3 and are also sent to the peripherals. The intended setup order is latch first, then direction, then ownership. In that order a pad that becomes an input or open-drain pin never drives a wrong level on the way.

Top module: `muxio_port`

## Requirements
- R1: A synchronous active-high reset clears the latch, direction and ownership bytes to 0x00. From the first cycle after reset, every pad is therefore a push-pull output of 0 (padOe all ones, padOut all zeros).
- R2: A write with regWrEn high stores regWrData at the clock edge into the byte selected by regAddr (0 latch, 1 direction, 2 ownership). Reading the same address returns that value combinationally. A write to one address leaves the other two bytes unchanged.
- R3: While a pin's ownership bit is 1, padOut and padOe for that pin follow periphOut and periphOe, whatever its direction and latch bits hold.
- R4: With ownership 0 and direction 0, the pin drives padOe=1 and padOut equal to its latch bit.
- R5: With ownership 0, direction 1 and latch 1, the pin is an input and padOe=0.
- R6: With ownership 0, direction 1 and latch 0, the pin is open-drain pulling low: padOe=1 and padOut=0.
- R7: Address 3 returns the pad levels through a two-flop synchronizer. A level applied before clock edge k shows up after edge k+1 and not after edge k alone.
- R8: periphIn carries the same synchronized pad levels for every pin, in every mode.
- R9: Writes to address 3 are ignored. All three control bytes and the pads keep their state.
- R10: Each pin's mode depends only on its own three bits, so one port can hold all four modes at the same time.
- R11: A control write changes the pads in the cycle right after the write edge. Programming latch 1 before setting direction 1 takes a pin from driven-high to input with no open-drain low step in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 latch, 1 direction, 2 ownership, 3 pin levels) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| padIn | input | 8 | Pad input levels |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| periphOut | input | 8 | Peripheral data for owned pins |
| periphOe | input | 8 | Peripheral enables for owned pins |
| periphIn | output | 8 | Synchronized pad levels to peripherals |

## Verification
The hardest case to reach from the ports is the change from output to input. A test that only looks at settled modes cannot tell whether the pin dropped into open-drain low for a cycle. The bench walks the write order one register at a time and checks the pads after each single write. It also checks the synchronizer cycle by cycle: it changes padIn, then reads address 3 after one edge and again after two edges, so that a missing or extra stage shows up.

// File: rtl/muxio_pkg.sv
package muxio_pkg;

  // Register select decoded from the two-bit address
  typedef enum logic [1:0] {
    SEL_LATCH = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_OWN   = 2'd2,
    SEL_PINS  = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    wrLatch;
    logic    wrDir;
    logic    wrOwn;
    regSel_e rdSel;
  } portStrobe_t;

  // Per-pin operating mode
  typedef enum logic [1:0] {
    PIN_PUSH  = 2'd0,
    PIN_INPUT = 2'd1,
    PIN_ODRAIN = 2'd2,
    PIN_ALT   = 2'd3
  } pinMode_e;

  // Ownership has priority; otherwise direction, then latch picks input/open-drain
  function automatic pinMode_e decodePin(input logic own, input logic dir, input logic lat);
    if (own)       return PIN_ALT;
    else if (!dir) return PIN_PUSH;
    else if (lat)  return PIN_INPUT;
    else           return PIN_ODRAIN;
  endfunction

endpackage

// File: rtl/muxio_ctrl.sv
module muxio_ctrl
  import muxio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  output portStrobe_t strobe
);

  regSel_e sel;
  assign sel = regSel_e'(regAddr);

  always_comb begin
    strobe         = '0;
    strobe.rdSel   = sel;
    strobe.wrLatch = regWrEn && (sel == SEL_LATCH);
    strobe.wrDir   = regWrEn && (sel == SEL_DIR);
    strobe.wrOwn   = regWrEn && (sel == SEL_OWN);
  end

  // R2: at most one byte written per cycle
  p_one_target_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.wrLatch, strobe.wrDir, strobe.wrOwn}));

  // R9: pin-level address never produces a write strobe
  p_pins_readonly_r9: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == 2'd3) |-> !(strobe.wrLatch || strobe.wrDir || strobe.wrOwn));

endmodule

// File: rtl/muxio_datapath.sv
module muxio_datapath
  import muxio_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  portStrobe_t          strobe,
  input  logic [PIN_COUNT-1:0] wrData,
  output logic [PIN_COUNT-1:0] rdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  input  logic [PIN_COUNT-1:0] periphOut,
  input  logic [PIN_COUNT-1:0] periphOe,
  output logic [PIN_COUNT-1:0] periphIn
);

  logic [PIN_COUNT-1:0] latchReg, dirReg, ownReg;
  logic [PIN_COUNT-1:0] syncMeta, syncPins;

  always_ff @(posedge clk) begin
    if (rst) begin
      latchReg <= '0;
      dirReg   <= '0;
      ownReg   <= '0;
    end else begin
      if (strobe.wrLatch) latchReg <= wrData;
      if (strobe.wrDir)   dirReg   <= wrData;
      if (strobe.wrOwn)   ownReg   <= wrData;
    end
  end

  // Two-flop synchronizer
  always_ff @(posedge clk) begin
    if (rst) begin
      syncMeta <= '0;
      syncPins <= '0;
    end else begin
      syncMeta <= padIn;
      syncPins <= syncMeta;
    end
  end

  assign periphIn = syncPins;

  always_comb begin
    unique case (strobe.rdSel)
      SEL_LATCH: rdData = latchReg;
      SEL_DIR:   rdData = dirReg;
      SEL_OWN:   rdData = ownReg;
      default:   rdData = syncPins;
    endcase
  end

  for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
    pinMode_e mode;
    assign mode = decodePin(ownReg[g], dirReg[g], latchReg[g]);

    always_comb begin
      unique case (mode)
        PIN_ALT:    begin padOut[g] = periphOut[g]; padOe[g] = periphOe[g]; end
        PIN_PUSH:   begin padOut[g] = latchReg[g];  padOe[g] = 1'b1;        end
        PIN_INPUT:  begin padOut[g] = 1'b0;         padOe[g] = 1'b0;        end
        default:    begin padOut[g] = 1'b0;         padOe[g] = 1'b1;        end
      endcase
    end

    // R3: peripheral owns the pad regardless of direction/latch
    p_alt_owns_r3: assert property (@(posedge clk) disable iff (rst)
      ownReg[g] |-> (padOut[g] == periphOut[g] && padOe[g] == periphOe[g]));

    // R5: input pins are released
    p_input_released_r5: assert property (@(posedge clk) disable iff (rst)
      (!ownReg[g] && dirReg[g] && latchReg[g]) |-> !padOe[g]);

    // R6: open-drain only ever pulls low
    p_odrain_low_r6: assert property (@(posedge clk) disable iff (rst)
      (!ownReg[g] && dirReg[g] && !latchReg[g]) |-> (padOe[g] && !padOut[g]));
  end

  // Checker bookkeeping: cycles since reset, saturating at 2
  logic [1:0] settleCnt;
  always_ff @(posedge clk) begin
    if (rst) settleCnt <= '0;
    else if (settleCnt != 2'd2) settleCnt <= settleCnt + 2'd1;
  end

  // R2: written byte lands at the edge
  p_latch_write_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.wrLatch |=> latchReg == $past(wrData));

  // R9: ownership byte unchanged without its own strobe
  p_own_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strobe.wrOwn |=> $stable(ownReg));

  // R7: pin levels lag the pads by exactly two edges
  p_sync_depth_r7: assert property (@(posedge clk) disable iff (rst)
    (settleCnt == 2'd2) |-> syncPins == $past(padIn, 2));

endmodule

// File: rtl/muxio_port.sv
module muxio_port
  import muxio_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [PIN_COUNT-1:0] regWrData,
  output logic [PIN_COUNT-1:0] regRdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  input  logic [PIN_COUNT-1:0] periphOut,
  input  logic [PIN_COUNT-1:0] periphOe,
  output logic [PIN_COUNT-1:0] periphIn
);

  portStrobe_t strobe;

  muxio_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .regWrEn (regWrEn),
    .regAddr (regAddr[1:0]),
    .strobe  (strobe)
  );

  muxio_datapath #(.PIN_COUNT(PIN_COUNT)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .wrData    (regWrData),
    .rdData    (regRdData),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .periphOut (periphOut),
    .periphOe  (periphOe),
    .periphIn  (periphIn)
  );

  // R1: the cycle after reset every pad is a push-pull output of 0
  p_reset_pads_r1: assert property (@(posedge clk)
    $past(rst) |-> (padOe == '1 && padOut == '0));

endmodule

// File: tb/muxio_port_test.sv
module muxio_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst = 1;
  logic       regWrEn = 0;
  logic [1:0] regAddr = 0;
  logic [7:0] regWrData = 0, regRdData;
  logic [7:0] padIn = 0, padOut, padOe;
  logic [7:0] periphOut = 0, periphOe = 0, periphIn;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muxio_port uut (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .periphOut(periphOut),
    .periphOe(periphOe), .periphIn(periphIn)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  // Expected pad controls from the mode rules
  function automatic logic [15:0] expPads(input logic [7:0] lat, input logic [7:0] dir,
                                          input logic [7:0] own, input logic [7:0] pOut,
                                          input logic [7:0] pOe);
    logic [7:0] oe, out;
    for (int i = 0; i < 8; i++) begin
      if (own[i])       begin out[i] = pOut[i]; oe[i] = pOe[i]; end
      else if (!dir[i]) begin out[i] = lat[i];  oe[i] = 1'b1;   end
      else if (lat[i])  begin out[i] = 1'b0;    oe[i] = 1'b0;   end
      else              begin out[i] = 1'b0;    oe[i] = 1'b1;   end
    end
    return {oe, out};
  endfunction

  task automatic checkPads(input string req, input logic [7:0] lat, input logic [7:0] dir,
                           input logic [7:0] own);
    logic [15:0] e;
    #1;
    e = expPads(lat, dir, own, periphOut, periphOe);
    chk({req, " padOe"}, padOe, e[15:8]);
    chk({req, " padOut"}, padOut, e[7:0]);
  endtask

  task automatic test_reset();
    logic [7:0] d;
    @(negedge clk);
    chk("R1 padOe", padOe, 8'hFF);
    chk("R1 padOut", padOut, 8'h00);
    readReg(2'd0, d); chk("R1 latch", d, 8'h00);
    readReg(2'd1, d); chk("R1 dir", d, 8'h00);
    readReg(2'd2, d); chk("R1 own", d, 8'h00);
  endtask

  task automatic test_regs();
    logic [7:0] d;
    writeReg(2'd0, 8'h5A);
    writeReg(2'd1, 8'hC3);
    writeReg(2'd2, 8'h00);
    readReg(2'd0, d); chk("R2 latch", d, 8'h5A);
    readReg(2'd1, d); chk("R2 dir", d, 8'hC3);
    readReg(2'd2, d); chk("R2 own", d, 8'h00);
    writeReg(2'd1, 8'h00);
    readReg(2'd0, d); chk("R2 latch kept", d, 8'h5A);
  endtask

  task automatic test_pushpull();
    writeReg(2'd2, 8'h00);
    writeReg(2'd1, 8'h00);
    writeReg(2'd0, 8'h96);
    checkPads("R4", 8'h96, 8'h00, 8'h00);
  endtask

  task automatic test_input();
    writeReg(2'd0, 8'hFF);
    writeReg(2'd1, 8'hFF);
    checkPads("R5", 8'hFF, 8'hFF, 8'h00);
  endtask

  task automatic test_odrain();
    writeReg(2'd0, 8'h00);
    checkPads("R6", 8'h00, 8'hFF, 8'h00);
  endtask

  task automatic test_periph();
    periphOut = 8'hA5; periphOe = 8'h3C;
    writeReg(2'd2, 8'hFF);
    checkPads("R3 dir1 lat0", 8'h00, 8'hFF, 8'hFF);
    writeReg(2'd1, 8'h00);
    writeReg(2'd0, 8'hFF);
    checkPads("R3 dir0 lat1", 8'hFF, 8'h00, 8'hFF);
    @(negedge clk);
    periphOut = 8'h0F; periphOe = 8'hF0;
    checkPads("R3 follow", 8'hFF, 8'h00, 8'hFF);
    writeReg(2'd2, 8'h00);
  endtask

  task automatic test_sync();
    logic [7:0] d;
    @(negedge clk); padIn = 8'h00;
    repeat (3) @(negedge clk);
    padIn = 8'hA5;
    @(negedge clk);
    readReg(2'd3, d); chk("R7 one edge", d, 8'h00);
    @(negedge clk);
    readReg(2'd3, d); chk("R7 two edges", d, 8'hA5);
    chk("R8 periphIn", periphIn, 8'hA5);
  endtask

  task automatic test_ignore();
    logic [7:0] d;
    writeReg(2'd0, 8'h33);
    writeReg(2'd1, 8'h0F);
    writeReg(2'd2, 8'h00);
    writeReg(2'd3, 8'hCC);
    readReg(2'd0, d); chk("R9 latch", d, 8'h33);
    readReg(2'd1, d); chk("R9 dir", d, 8'h0F);
    readReg(2'd2, d); chk("R9 own", d, 8'h00);
    readReg(2'd3, d); chk("R9 pins", d, 8'hA5);
    checkPads("R9", 8'h33, 8'h0F, 8'h00);
  endtask

  task automatic test_mixed();
    // pins 7:6 alt, 5:4 push, 3:2 input, 1:0 open-drain
    periphOut = 8'h80; periphOe = 8'hC0;
    writeReg(2'd0, 8'b0001_1100);
    writeReg(2'd1, 8'b0000_1111);
    writeReg(2'd2, 8'b1100_0000);
    checkPads("R10", 8'b0001_1100, 8'b0000_1111, 8'b1100_0000);
    writeReg(2'd2, 8'h00);
  endtask

  task automatic test_order();
    writeReg(2'd1, 8'h00);
    writeReg(2'd0, 8'h00);
    // Latch first: still push-pull, now high
    writeReg(2'd0, 8'hFF);
    checkPads("R11 after latch", 8'hFF, 8'h00, 8'h00);
    // Direction next: straight to input, never open-drain low
    writeReg(2'd1, 8'hFF);
    checkPads("R11 after dir", 8'hFF, 8'hFF, 8'h00);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    test_reset();
    test_regs();
    test_pushpull();
    test_input();
    test_odrain();
    test_periph();
    test_sync();
    test_ignore();
    test_mixed();
    test_order();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule